// File: doc/BRIEF.md
# Register Write-Protection Guard

This block fronts a small bank of configuration registers on a synchronous memory-mapped bus. It guards them against stray software writes. A mode register holds a protection enable bit. That enable bit changes only when the write carries a fixed 24-bit access key in the upper bits of the data word.

While protection is on, writes aimed at the guarded registers are dropped. The guarded registers are the per-pad delay words and a control word. Each refused write sets a sticky violation flag and records the word offset that was targeted. The flag stays set until a correctly keyed write to the mode register clears it. The offset is kept until the next refused write replaces it.

Each pad has a 4-bit delay field. 0x0 means no added delay and is the reset value. 0xF means the largest delay. The delay fields and the control word are driven out of the block continuously. The function of these settings lies outside this block. A pair of general-purpose words is never guarded.

Top module: `reg_wp_guard`

## Requirements
- R1: After reset, protection is off, the violation flag and the source offset are 0, and every storage word reads 0.
- R2: A write to the mode word (offset 0x00) whose bits [31:8] equal the key 0xC3A95E loads the enable from bit 0 and clears the violation flag. A mode write with any other key changes neither the enable bit nor the status.
- R3: With protection on, a write to a guarded offset leaves that register unchanged. The guarded offsets are 0x04 and 0x05 (the delay words) and 0x08 (the control word).
- R4: With protection on, a write to a guarded offset sets the violation flag and loads the source field with that offset, both visible on the next cycle.
- R5: Further refused writes before a clear keep the flag set, and the source field holds the offset of the latest attempt.
- R6: With protection off, writes to guarded offsets update the registers normally.
- R7: Writes to the free words at offsets 0x0C and 0x0D always complete and never set the violation flag.
- R8: The status word (offset 0x01) is read-only, and writes to it leave the flag and the source field unchanged.
- R9: Reads return data on the cycle after the read strobe. The mode word reads the enable in bit 0, with 0 in all other bits. The status word reads the flag in bit 0 and the source in bits [13:8]. Storage words read their contents. Unmapped offsets read 0 and ignore writes.
- R10: The delay of pad p sits in bits [4(p mod 8)+3 : 4(p mod 8)] of the word at offset 0x04 + p/8. It appears on pad_delay[4p+3:4p], and the control word appears on ctrl_cfg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Word offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_delay | output | 48 | Per-pad 4-bit delay settings |
| ctrl_cfg | output | 32 | Control word contents |

## Verification
On every cycle, the embedded assertions check four things:
- a wrongly keyed mode write leaves the enable unchanged, and a keyed write clears the flag;
- a refused write leaves the guarded storage stable and captures the flag and the offset;
- the flag stays set until it is cleared;
- writes to the status word or to the free words do not disturb the violation state.

Only the bench's scenarios can show the rest. That covers the read-back word layouts, and that the source tracks the most recent of several violations. It also covers that the delay fields land on the right pads, and that the same guarded write succeeds once protection is turned off again.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 32;
    localparam int KEY_W     = 24;
    localparam int KEY_LSB   = DATA_W - KEY_W;
    localparam int DLY_W     = 4;
    localparam int PADS_PER_WORD = DATA_W / DLY_W;
    localparam int SRC_LSB   = 8;

    localparam logic [KEY_W-1:0] WP_KEY = 24'hC3A95E;

    localparam int OFS_MODE  = 0;
    localparam int OFS_STAT  = 1;
    localparam int OFS_DLY   = 4;
    localparam int OFS_CTRL  = 8;
    localparam int OFS_FREE  = 12;
    localparam int NUM_FREE  = 2;

    typedef enum logic [2:0] {
        RG_MODE,
        RG_STAT,
        RG_DLY,
        RG_CTRL,
        RG_FREE,
        RG_NONE
    } reg_kind_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    typedef struct packed {
        logic              flag;
        logic [ADDR_W-1:0] src;
    } viol_t;

    function automatic reg_kind_e decode_ofs(input logic [ADDR_W-1:0] a, input int ndly);
        int ai;
        ai = int'(a);
        if (ai == OFS_MODE) return RG_MODE;
        if (ai == OFS_STAT) return RG_STAT;
        if (ai >= OFS_DLY && ai < OFS_DLY + ndly) return RG_DLY;
        if (ai == OFS_CTRL) return RG_CTRL;
        if (ai >= OFS_FREE && ai < OFS_FREE + NUM_FREE) return RG_FREE;
        return RG_NONE;
    endfunction

    function automatic logic is_guarded(input reg_kind_e k);
        return (k == RG_DLY) || (k == RG_CTRL);
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input viol_t v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = v.flag;
        w[SRC_LSB +: ADDR_W] = v.src;
        return w;
    endfunction

endpackage

// File: rtl/wpg_mode_reg.sv
module wpg_mode_reg
    import wpg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_req_t  req,
    input  reg_kind_e kind,
    output logic      prot_en,
    output logic      key_clear
);

    logic mode_wr;
    logic key_match;

    always_comb begin
        mode_wr   = req.wr && (kind == RG_MODE);
        key_match = (req.data[KEY_LSB +: KEY_W] == WP_KEY);
        key_clear = mode_wr && key_match;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_en <= 1'b0;
        end else if (key_clear) begin
            prot_en <= req.data[0];
        end
    end

    AST_BAD_KEY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && !key_match) |=> $stable(prot_en)); // R2

endmodule

// File: rtl/wpg_viol_track.sv
module wpg_viol_track
    import wpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              blocked,
    input  logic [ADDR_W-1:0] addr,
    input  logic              clear,
    output viol_t             st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (blocked) begin
            st.flag <= 1'b1;
            st.src  <= addr;
        end else if (clear) begin
            st.flag <= 1'b0;
        end
    end

    AST_VIOL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        blocked |=> (st.flag && st.src == $past(addr))); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st.flag && !clear) |=> st.flag); // R5

    AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clear && !blocked) |=> !st.flag); // R2

endmodule

// File: rtl/wpg_cfg_bank.sv
module wpg_cfg_bank
    import wpg_pkg::*;
#(
    parameter int NUM_DLY = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  bus_req_t                    req,
    input  reg_kind_e                   kind,
    input  logic                        prot_en,
    output logic                        blocked,
    output logic [NUM_DLY*DATA_W-1:0]   dly_q,
    output logic [DATA_W-1:0]           ctrl_q,
    output logic [DATA_W-1:0]           rd_word
);

    logic [NUM_FREE*DATA_W-1:0] free_q;
    logic                       wr_ok;
    int                         dly_idx;
    int                         free_idx;

    always_comb begin
        blocked  = req.wr && is_guarded(kind) && prot_en;
        wr_ok    = req.wr && !prot_en;
        dly_idx  = int'(req.addr) - OFS_DLY;
        free_idx = int'(req.addr) - OFS_FREE;
    end

    for (genvar g = 0; g < NUM_DLY; g++) begin : g_dly
        always_ff @(posedge clk) begin
            if (rst) begin
                dly_q[g*DATA_W +: DATA_W] <= '0;
            end else if (wr_ok && kind == RG_DLY && dly_idx == g) begin
                dly_q[g*DATA_W +: DATA_W] <= req.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ok && kind == RG_CTRL) begin
            ctrl_q <= req.data;
        end
    end

    for (genvar f = 0; f < NUM_FREE; f++) begin : g_free
        always_ff @(posedge clk) begin
            if (rst) begin
                free_q[f*DATA_W +: DATA_W] <= '0;
            end else if (req.wr && kind == RG_FREE && free_idx == f) begin
                free_q[f*DATA_W +: DATA_W] <= req.data;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        case (kind)
            RG_DLY: begin
                for (int i = 0; i < NUM_DLY; i++) begin
                    if (dly_idx == i) rd_word = dly_q[i*DATA_W +: DATA_W];
                end
            end
            RG_CTRL: rd_word = ctrl_q;
            RG_FREE: begin
                for (int i = 0; i < NUM_FREE; i++) begin
                    if (free_idx == i) rd_word = free_q[i*DATA_W +: DATA_W];
                end
            end
            default: rd_word = '0;
        endcase
    end

    AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        blocked |=> ($stable(dly_q) && $stable(ctrl_q))); // R3

endmodule

// File: rtl/reg_wp_guard.sv
module reg_wp_guard
    import wpg_pkg::*;
#(
    parameter int NUM_PADS = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [NUM_PADS*DLY_W-1:0] pad_delay,
    output logic [DATA_W-1:0]         ctrl_cfg
);

    localparam int NUM_DLY = (NUM_PADS + PADS_PER_WORD - 1) / PADS_PER_WORD;

    bus_req_t                  req;
    reg_kind_e                 kind;
    logic                      prot_en;
    logic                      key_clear;
    logic                      blocked;
    viol_t                     viol;
    logic [NUM_DLY*DATA_W-1:0] dly_q;
    logic [DATA_W-1:0]         bank_word;
    logic [DATA_W-1:0]         rd_mux;

    always_comb begin
        req.wr   = bus_wr;
        req.rd   = bus_rd;
        req.addr = bus_addr;
        req.data = bus_wdata;
        kind     = decode_ofs(bus_addr, NUM_DLY);
    end

    wpg_mode_reg u_mode (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .kind      (kind),
        .prot_en   (prot_en),
        .key_clear (key_clear)
    );

    wpg_cfg_bank #(.NUM_DLY(NUM_DLY)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .kind    (kind),
        .prot_en (prot_en),
        .blocked (blocked),
        .dly_q   (dly_q),
        .ctrl_q  (ctrl_cfg),
        .rd_word (bank_word)
    );

    wpg_viol_track u_viol (
        .clk     (clk),
        .rst     (rst),
        .blocked (blocked),
        .addr    (bus_addr),
        .clear   (key_clear),
        .st      (viol)
    );

    always_comb begin
        case (kind)
            RG_MODE: rd_mux = {{(DATA_W-1){1'b0}}, prot_en};
            RG_STAT: rd_mux = pack_status(viol);
            default: rd_mux = bank_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (req.rd) begin
            bus_rdata <= rd_mux;
        end
    end

    assign pad_delay = dly_q[NUM_PADS*DLY_W-1:0];

    AST_FREE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!viol.flag && bus_wr && kind == RG_FREE) |=> !viol.flag); // R7

    AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && kind == RG_STAT) |=> $stable(viol)); // R8

endmodule

// File: tb/reg_wp_guard_bench.sv
`timescale 1ns/1ps
module reg_wp_guard_bench;

    localparam logic [23:0] KEY = 24'hC3A95E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [47:0] pad_delay;
    logic [31:0] ctrl_cfg;

    always #2.5 clk = ~clk;

    reg_wp_guard u_reg_wp_guard (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pad_delay (pad_delay),
        .ctrl_cfg  (ctrl_cfg)
    );

    // behavioural reference state
    logic [31:0] m_mem [0:63];
    logic        m_en;
    logic        m_flag;
    logic [5:0]  m_src;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          live = 1'b0;

    function automatic bit m_guarded(input int a);
        return (a == 4) || (a == 5) || (a == 8);
    endfunction

    function automatic bit m_free(input int a);
        return (a == 12) || (a == 13);
    endfunction

    function automatic logic [31:0] m_read(input int a);
        if (a == 0) return {31'b0, m_en};
        if (a == 1) return {18'b0, m_src, 7'b0, m_flag};
        if (m_guarded(a) || m_free(a)) return m_mem[a];
        return 32'h0;
    endfunction

    task automatic m_write(input int a, input logic [31:0] d);
        if (a == 0) begin
            if (d[31:8] == KEY) begin
                m_en   = d[0];
                m_flag = 1'b0;
            end
        end else if (m_guarded(a)) begin
            if (m_en) begin
                m_flag = 1'b1;
                m_src  = a[5:0];
            end else begin
                m_mem[a] = d;
            end
        end else if (m_free(a)) begin
            m_mem[a] = d;
        end
    endtask

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare outputs with the model on every clock
    always @(negedge clk) begin
        if (live) begin
            chk({16'b0, pad_delay}, {16'b0, m_mem[5][15:0], m_mem[4]}, "R10 pad_delay");
            chk({32'b0, ctrl_cfg}, {32'b0, m_mem[8]}, "R3/R6 ctrl_cfg");
        end
    end

    task automatic do_wr(input int a, input logic [31:0] d);
        bus_addr  = a[5:0];
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #0.1 m_write(a, d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input int a, input string tag);
        logic [31:0] exp;
        exp      = m_read(a);
        bus_addr = a[5:0];
        bus_rd   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        chk({32'b0, bus_rdata}, {32'b0, exp}, tag);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        m_en = 1'b0; m_flag = 1'b0; m_src = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        live = 1'b1;

        // R1 reset state
        do_rd(0, "R1 mode after reset");
        do_rd(1, "R1 status after reset");
        do_rd(4, "R1 delay word after reset");
        do_rd(8, "R1 ctrl after reset");
        chk({32'b0, bus_rdata}, 64'h0, "R1 rdata zero");

        // R6 unprotected writes to guarded registers
        do_wr(4, 32'hF0000001);
        do_wr(5, 32'h0000A5F3);
        do_wr(8, 32'h12345678);
        do_rd(4, "R6 delay word 0 written");
        do_rd(5, "R6 delay word 1 written");
        do_rd(8, "R6 ctrl written");
        chk({60'b0, pad_delay[31:28]}, 64'hF, "R10 pad7 max delay");
        chk({60'b0, pad_delay[35:32]}, 64'h3, "R10 pad8 field");

        // R2 wrong key does nothing
        do_wr(0, {24'h123456, 8'h01});
        do_rd(0, "R2 wrong key keeps enable off");
        do_wr(8, 32'hAAAA0000);
        do_rd(1, "R2 no violation while off");

        // R2 right key enables
        do_wr(0, {KEY, 8'h01});
        do_rd(0, "R2 keyed enable");

        // R3 / R4 blocked write
        do_wr(8, 32'hDEADBEEF);
        do_rd(8, "R3 ctrl unchanged");
        do_rd(1, "R4 flag and source 0x08");
        chk({58'b0, bus_rdata[13:8]}, 64'h8, "R4 source field offset 8");

        // R5 latest source kept
        do_wr(4, 32'h11111111);
        do_wr(5, 32'h22222222);
        do_rd(1, "R5 source is latest (0x05)");
        do_rd(5, "R3 delay word 1 unchanged");

        // R8 status write ignored
        do_wr(1, 32'h00000000);
        do_rd(1, "R8 status unchanged by write");

        // R2 wrong key does not clear the flag
        do_wr(0, {24'hC3A95F, 8'h00});
        do_rd(1, "R2 wrong key keeps flag");
        do_rd(0, "R2 wrong key keeps enable on");

        // R7 free words always writable
        do_wr(0, {KEY, 8'h01});
        do_rd(1, "R2 keyed write clears flag");
        do_wr(12, 32'hCAFEF00D);
        do_wr(13, 32'h0BADC0DE);
        do_rd(12, "R7 free word 0 written");
        do_rd(13, "R7 free word 1 written");
        do_rd(1, "R7 no flag from free writes");

        // R9 unmapped offsets
        do_wr(6, 32'hFFFFFFFF);
        do_rd(6, "R9 unmapped reads zero");
        do_rd(1, "R9 unmapped write sets no flag");

        // R6 disable and write again
        do_wr(0, {KEY, 8'h00});
        do_rd(0, "R6 protection off");
        do_wr(8, 32'h0F0F0F0F);
        do_rd(8, "R6 ctrl writable again");
        do_rd(1, "R6 no flag when off");

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

endmodule